// File: doc/BRIEF.md
# Packet-Organized OTP Read Controller

This block sits between a small register bus and a word-addressed one-time-programmable array. The array holds variable-length records. Each record opens with one 32-bit header word, and its payload words follow directly after it. Software places a word address in the upper half of the mode register and then sets the go bit in the control register. The controller walks the record headers from word 0 until it reaches the record whose span covers the requested word. It then copies that record's header into a header register and its payload into a local buffer. While this happens a busy flag is raised in the status register.

The same record is returned for any requested word inside it, whether that word is the header or any payload word. The requested word itself is never what comes back. Once busy drops, software reads the header register. It then sets a payload index and pulls payload words one after another through a data register. The array is modelled as a synchronous ROM whose image is computed at elaboration from parameters. The array cannot be programmed.

Top module: `otp_pkt_ctrl`

## Requirements
- R1: After reset the status register (0x0C) reads 0, the header register (0x20) reads 0 and a data register read (0x24) returns 0.
- R2: A request for any word address from a record's header through its last payload word loads that record. The header register holds the record's header word, and the payload holds (header bits 15:8) + 1 words taken in address order from the word after the header.
- R3: Writing a word with bit 6 set to the control register (0x00) starts a fetch for the word address held in bits 31:16 of the mode register (0x04). The address is captured at start, so a start or a mode write issued while busy does not change the record being fetched.
- R4: Status bit 6 is busy. It is set from the clock edge that accepts the start, and it clears exactly 2·H + 2·(L+1) edges later on success, or 2·H edges later on failure. H is the number of headers read, each step moving (L+2) words forward from word 0, and L is the found record's length field.
- R5: Writing the payload index register (0x08) selects that payload word. Each data register read returns the selected word and advances the index by one on the same clock edge.
- R6: A data register read whose index is at or beyond the payload word count returns 0.
- R7: A header whose length field (bits 15:8) is zero ends the fetch with status bit 0 set. After a failed fetch the header register reads 0 and every data read returns 0. A new start clears bit 0.
- R8: A fetch also fails with status bit 0 when the next record would start beyond the array end before the requested address is reached. It fails too when a record's payload would run past the last array word.
- R9: The mode register reads back the last value written to it.
- R10: ROM image: record k (k below NUM_PKTS) has the length field L = 1 + ((5k + IMG_SEED) mod 7) and the header {8'hC3, k[7:0], L, 8'h5A}. The payload word stored at array address a is {16'hD00D, a[15:0]}. Records are packed from address 0, the image is cut at the array end, and all words after the last record are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, sampled on the clock edge |
| bus_rd | input | 1 | Register read strobe; a data register read advances the index on the edge |
| bus_addr | input | BUS_AW | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr while bus_rd is high |

## Verification
A start written on one clock edge shows busy right after that edge. The bench polls status once per cycle and compares busy against a reference count of 2·H + 2·(L+1) edges on success, or 2·H on failure, derived by walking the record list in the bench. The fail bit is checked on the first cycle busy is expected low. Header and payload reads are combinational and are sampled one time unit after the falling edge. Each data read is held across one rising edge, so the following read sees the advanced index. A second instance with a shorter array exercises the run-past-end failures.

// File: rtl/otp_pkt_pkg.sv
package otp_pkt_pkg;

   // register byte offsets (software-visible layout)
   localparam int unsigned OFS_CTRL = 'h00;
   localparam int unsigned OFS_MODE = 'h04;
   localparam int unsigned OFS_IDX  = 'h08;
   localparam int unsigned OFS_STAT = 'h0C;
   localparam int unsigned OFS_HDR  = 'h20;
   localparam int unsigned OFS_DATA = 'h24;

   // bit positions
   localparam int unsigned GO_BIT     = 6;
   localparam int unsigned BUSY_BIT   = 6;
   localparam int unsigned FAIL_BIT   = 0;
   localparam int unsigned MADDR_LSB  = 16;
   localparam int unsigned MADDR_W    = 16;
   localparam int unsigned LEN_LSB    = 8;
   localparam int unsigned LEN_W      = 8;
   localparam int unsigned WORD_W     = 32;

   typedef enum logic [2:0] {
      F_IDLE,
      F_WALK_A,
      F_WALK_D,
      F_COPY_A,
      F_COPY_D
   } fetch_st_t;

endpackage

// File: rtl/otp_img_rom.sv
module otp_img_rom #(
   parameter int unsigned WORDS    = 2816,
   parameter int unsigned AW       = 12,
   parameter int unsigned NUM_PKTS = 6,
   parameter int unsigned IMG_SEED = 3
) (
   input  logic          clk,
   input  logic [AW-1:0] addr,
   output logic [31:0]   q
);

   logic [31:0] mem [WORDS];

   // elaboration-time image: packed records, cut at the array end
   initial begin
      int unsigned pos;
      int unsigned len;
      for (int unsigned a = 0; a < WORDS; a++) mem[a] = '0;
      pos = 0;
      for (int unsigned k = 0; k < NUM_PKTS; k++) begin
         len = 1 + ((k * 5 + IMG_SEED) % 7);
         if (pos < WORDS)
            mem[pos] = {8'hC3, 8'(k), 8'(len), 8'h5A};
         for (int unsigned j = 1; j <= len + 1; j++) begin
            if (pos + j < WORDS)
               mem[pos + j] = {16'hD00D, 16'(pos + j)};
         end
         pos = pos + len + 2;
      end
   end

   always_ff @(posedge clk) begin
      q <= mem[addr];
   end

endmodule

// File: rtl/otp_pkt_fetch.sv
module otp_pkt_fetch import otp_pkt_pkg::*; #(
   parameter int unsigned WORDS = 2816,
   parameter int unsigned AW    = 12,
   parameter int unsigned TW    = 16,
   parameter int unsigned IW    = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [TW-1:0] target,
   input  logic [31:0]   rom_q,
   output logic [AW-1:0] rom_addr,
   output logic          busy,
   output logic          fail,
   output logic [31:0]   hdr,
   output logic [IW-1:0] pay_words,
   output logic          ld_en,
   output logic [IW-1:0] ld_idx,
   output logic [31:0]   ld_data
);

   localparam int unsigned PW = TW + 1;

   fetch_st_t          st;
   logic [TW-1:0]      tgt;
   logic [PW-1:0]      pos;
   logic [IW-1:0]      cnt;
   logic [LEN_W-1:0]   hlen;
   logic [PW-1:0]      nxt;
   logic               hit;
   logic               bad;

   assign hlen = rom_q[LEN_LSB +: LEN_W];
   assign nxt  = pos + PW'(hlen) + PW'(2);
   assign hit  = {1'b0, tgt} < nxt;
   assign bad  = (hlen == '0) || (nxt > PW'(WORDS)) || (!hit && (nxt == PW'(WORDS)));

   always_comb begin
      if (st == F_COPY_A) rom_addr = AW'(pos + PW'(cnt) + PW'(1));
      else                rom_addr = AW'(pos);
   end

   assign busy    = (st != F_IDLE);
   assign ld_en   = (st == F_COPY_D);
   assign ld_idx  = cnt;
   assign ld_data = rom_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= F_IDLE;
         tgt       <= '0;
         pos       <= '0;
         cnt       <= '0;
         fail      <= 1'b0;
         hdr       <= '0;
         pay_words <= '0;
      end else begin
         unique case (st)
            F_IDLE: begin
               if (start) begin
                  tgt  <= target;
                  pos  <= '0;
                  fail <= 1'b0;
                  st   <= F_WALK_A;
               end
            end
            F_WALK_A: st <= F_WALK_D;
            F_WALK_D: begin
               if (bad) begin
                  fail      <= 1'b1;
                  hdr       <= '0;
                  pay_words <= '0;
                  st        <= F_IDLE;
               end else if (hit) begin
                  hdr       <= rom_q;
                  pay_words <= IW'(hlen) + IW'(1);
                  cnt       <= '0;
                  st        <= F_COPY_A;
               end else begin
                  pos <= nxt;
                  st  <= F_WALK_A;
               end
            end
            F_COPY_A: st <= F_COPY_D;
            F_COPY_D: begin
               cnt <= cnt + IW'(1);
               if (cnt == pay_words - IW'(1)) st <= F_IDLE;
               else                           st <= F_COPY_A;
            end
            default: st <= F_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/otp_pld_buf.sv
module otp_pld_buf #(
   parameter int unsigned DEPTH = 256,
   parameter int unsigned IW    = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_en,
   input  logic [IW-1:0] ld_idx,
   input  logic [31:0]   ld_data,
   input  logic [IW-1:0] avail,
   input  logic          idx_wr,
   input  logic [IW-1:0] idx_val,
   input  logic          rd_pop,
   output logic [IW-1:0] idx,
   output logic [31:0]   rd_data
);

   localparam int unsigned MAW = $clog2(DEPTH);

   logic [31:0] mem [DEPTH];
   logic        in_range;

   always_ff @(posedge clk) begin
      if (ld_en) mem[ld_idx[MAW-1:0]] <= ld_data;
   end

   assign in_range = (idx < avail);
   assign rd_data  = in_range ? mem[idx[MAW-1:0]] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  idx <= '0;
      else if (idx_wr)             idx <= idx_val;
      else if (rd_pop && in_range) idx <= idx + IW'(1);
   end

endmodule

// File: rtl/otp_pkt_ctrl.sv
module otp_pkt_ctrl import otp_pkt_pkg::*; #(
   parameter int unsigned WORDS    = 2816,
   parameter int unsigned NUM_PKTS = 6,
   parameter int unsigned IMG_SEED = 3,
   parameter int unsigned BUS_AW   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata
);

   localparam int unsigned AW        = (WORDS > 1) ? $clog2(WORDS) : 1;
   localparam int unsigned TW        = MADDR_W;
   localparam int unsigned PAY_DEPTH = 1 << LEN_W;
   localparam int unsigned IW        = $clog2(PAY_DEPTH) + 1;

   generate
      if (WORDS < 2 || WORDS > (1 << TW)) begin : g_bad_words
         $error("otp_pkt_ctrl: WORDS must be within 2 .. 2**address field width");
      end
      if (NUM_PKTS < 1) begin : g_bad_pkts
         $error("otp_pkt_ctrl: NUM_PKTS must be at least 1");
      end
      if (BUS_AW < 6) begin : g_bad_bus
         $error("otp_pkt_ctrl: BUS_AW too narrow for register offsets");
      end
   endgenerate

   logic [31:0]   mode_q;
   logic          busy;
   logic          fail;
   logic [31:0]   hdr_q;
   logic [IW-1:0] pay_words;
   logic [AW-1:0] rom_addr;
   logic [31:0]   rom_q;
   logic          ld_en;
   logic [IW-1:0] ld_idx;
   logic [31:0]   ld_data;
   logic [IW-1:0] buf_idx;
   logic [31:0]   buf_rdata;
   logic          sel_ctrl, sel_mode, sel_idx, sel_stat, sel_hdr, sel_data;
   logic          go;

   assign sel_ctrl = (bus_addr == BUS_AW'(OFS_CTRL));
   assign sel_mode = (bus_addr == BUS_AW'(OFS_MODE));
   assign sel_idx  = (bus_addr == BUS_AW'(OFS_IDX));
   assign sel_stat = (bus_addr == BUS_AW'(OFS_STAT));
   assign sel_hdr  = (bus_addr == BUS_AW'(OFS_HDR));
   assign sel_data = (bus_addr == BUS_AW'(OFS_DATA));

   assign go = bus_wr && sel_ctrl && bus_wdata[GO_BIT] && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 mode_q <= '0;
      else if (bus_wr && sel_mode) mode_q <= bus_wdata;
   end

   otp_img_rom #(
      .WORDS(WORDS), .AW(AW), .NUM_PKTS(NUM_PKTS), .IMG_SEED(IMG_SEED)
   ) u_rom (
      .clk(clk), .addr(rom_addr), .q(rom_q)
   );

   otp_pkt_fetch #(
      .WORDS(WORDS), .AW(AW), .TW(TW), .IW(IW)
   ) u_fetch (
      .clk(clk), .rst_n(rst_n), .start(go),
      .target(mode_q[MADDR_LSB +: MADDR_W]), .rom_q(rom_q), .rom_addr(rom_addr),
      .busy(busy), .fail(fail), .hdr(hdr_q), .pay_words(pay_words),
      .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data)
   );

   otp_pld_buf #(
      .DEPTH(PAY_DEPTH), .IW(IW)
   ) u_buf (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
      .avail(pay_words), .idx_wr(bus_wr && sel_idx), .idx_val(bus_wdata[IW-1:0]),
      .rd_pop(bus_rd && sel_data), .idx(buf_idx), .rd_data(buf_rdata)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         if (sel_mode) bus_rdata = mode_q;
         if (sel_stat) begin
            bus_rdata[BUSY_BIT] = busy;
            bus_rdata[FAIL_BIT] = fail;
         end
         if (sel_hdr)  bus_rdata = hdr_q;
         if (sel_data) bus_rdata = buf_rdata;
      end
   end

endmodule

// File: rtl/otp_pkt_ctrl_chk.sv
module otp_pkt_ctrl_chk import otp_pkt_pkg::*; #(
   parameter int unsigned BUS_AW = 6,
   parameter int unsigned IW     = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [BUS_AW-1:0] bus_addr,
   input logic              go_bit,
   input logic [31:0]       bus_rdata,
   input logic              busy,
   input logic              fail,
   input logic [IW-1:0]     idx,
   input logic [IW-1:0]     avail,
   input logic [LEN_W-1:0]  hdr_len
);

   // R3: an accepted go raises busy on the next cycle
   p_go_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == BUS_AW'(OFS_CTRL) && go_bit && !busy) |=> busy);

   // R7: a failed fetch is never still busy
   p_fail_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fail |-> !busy);

   // R7: failure leaves header and payload empty
   p_fail_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && !busy) |-> (avail == '0 && hdr_len == '0));

   // R2: a successful fetch exposes length field + 1 payload words
   p_len_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && !fail) |-> (avail == IW'(hdr_len) + IW'(1)));

   // R6: reads beyond the payload return zero
   p_past_end_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == BUS_AW'(OFS_DATA) && idx >= avail) |-> (bus_rdata == '0));

   // R5: an in-range data read advances the index by one
   p_idx_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_wr && bus_addr == BUS_AW'(OFS_DATA) && idx < avail)
      |=> (idx == $past(idx) + IW'(1)));

endmodule

bind otp_pkt_ctrl otp_pkt_ctrl_chk #(.BUS_AW(BUS_AW), .IW(IW)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
   .go_bit(bus_wdata[6]), .bus_rdata(bus_rdata), .busy(busy), .fail(fail),
   .idx(buf_idx), .avail(pay_words), .hdr_len(hdr_q[15:8])
);

// File: tb/tb_otp_pkt_ctrl.sv
module tb_otp_pkt_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int SEED       = 3;
   localparam int WORDS_A    = 64;
   localparam int PKTS_A     = 7;
   localparam int WORDS_B    = 44;
   localparam int PKTS_B     = 8;

   localparam logic [5:0] A_CTRL = 6'h00;
   localparam logic [5:0] A_MODE = 6'h04;
   localparam logic [5:0] A_IDX  = 6'h08;
   localparam logic [5:0] A_STAT = 6'h0C;
   localparam logic [5:0] A_HDR  = 6'h20;
   localparam logic [5:0] A_DATA = 6'h24;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] rdata_a;
   logic [31:0] rdata_b;

   int n_checks = 0;
   int n_errors = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   otp_pkt_ctrl #(.WORDS(WORDS_A), .NUM_PKTS(PKTS_A), .IMG_SEED(SEED), .BUS_AW(6)) dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_a));

   otp_pkt_ctrl #(.WORDS(WORDS_B), .NUM_PKTS(PKTS_B), .IMG_SEED(SEED), .BUS_AW(6)) dut_trunc (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_b));

   // ---------------- reference model (from R10 / R2 / R4 / R7 / R8) ----------------
   function automatic logic [31:0] img_word(int words, int npk, int a);
      int pos = 0;
      if (a >= words) return 32'h0;
      for (int k = 0; k < npk; k++) begin
         int ln = 1 + ((k * 5 + SEED) % 7);
         if (a == pos) return {8'hC3, 8'(k), 8'(ln), 8'h5A};
         if (a > pos && a <= pos + ln + 1) return {16'hD00D, 16'(a)};
         pos = pos + ln + 2;
      end
      return 32'h0;
   endfunction

   task automatic walk_model(input int words, input int npk, input int t,
                             output int nw, output bit ok, output int st, output int ln);
      int pos = 0;
      int nxt;
      logic [31:0] h;
      nw = 0; ok = 1'b0; st = 0; ln = 0;
      while (1) begin
         h   = img_word(words, npk, pos);
         nw  = nw + 1;
         nxt = pos + int'(h[15:8]) + 2;
         if (h[15:8] == 8'd0) return;
         if (nxt > words) return;
         if (t < nxt) begin ok = 1'b1; st = pos; ln = int'(h[15:8]); return; end
         if (nxt == words) return;
         pos = nxt;
      end
   endtask

   // ---------------- bus helpers ----------------
   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [5:0] a, output logic [31:0] ra, output logic [31:0] rb);
      bus_rd = 1'b1; bus_addr = a;
      #1;
      ra = rdata_a; rb = rdata_b;
      @(posedge clk);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic summary;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
   endtask

   // one request on both instances; optional interference while busy
   task automatic do_req(input int t, input bit interfere);
      int nw_a, st_a, ln_a, n_a, nw_b, st_b, ln_b, n_b, nmax;
      bit ok_a, ok_b;
      logic [31:0] ra, rb;
      walk_model(WORDS_A, PKTS_A, t, nw_a, ok_a, st_a, ln_a);
      walk_model(WORDS_B, PKTS_B, t, nw_b, ok_b, st_b, ln_b);
      n_a  = ok_a ? 2 * nw_a + 2 * (ln_a + 1) : 2 * nw_a;
      n_b  = ok_b ? 2 * nw_b + 2 * (ln_b + 1) : 2 * nw_b;
      nmax = (n_a > n_b) ? n_a : n_b;
      bus_write(A_MODE, 32'(t) << 16);
      bus_write(A_CTRL, 32'h0000_0040);
      for (int j = 0; j <= nmax; j++) begin
         if (interfere && j == 3) begin bus_write(A_MODE, 32'(t ^ 5) << 16); continue; end
         if (interfere && j == 4) begin bus_write(A_CTRL, 32'h0000_0040);    continue; end
         bus_read(A_STAT, ra, rb);
         if (j <= n_a) chk("R4", $sformatf("busy a t=%0d cyc=%0d", t, j), 32'(ra[6]), 32'(j < n_a));
         if (j <= n_b) chk("R4", $sformatf("busy b t=%0d cyc=%0d", t, j), 32'(rb[6]), 32'(j < n_b));
         if (j == n_a) chk(ok_a ? "R2" : "R7/R8", $sformatf("fail a t=%0d", t), 32'(ra[0]), 32'(!ok_a));
         if (j == n_b) chk(ok_b ? "R2" : "R8",    $sformatf("fail b t=%0d", t), 32'(rb[0]), 32'(!ok_b));
      end
      // header and payload on the main instance
      bus_write(A_IDX, 32'h0);
      bus_read(A_HDR, ra, rb);
      chk(ok_a ? "R2" : "R7", $sformatf("hdr a t=%0d", t), ra, ok_a ? img_word(WORDS_A, PKTS_A, st_a) : 32'h0);
      chk(ok_b ? "R2" : "R8", $sformatf("hdr b t=%0d", t), rb, ok_b ? img_word(WORDS_B, PKTS_B, st_b) : 32'h0);
      for (int w = 0; w <= (ok_a ? ln_a + 2 : 1); w++) begin
         bus_read(A_DATA, ra, rb);
         if (ok_a && w <= ln_a)
            chk("R5", $sformatf("payload a t=%0d w=%0d", t, w), ra, img_word(WORDS_A, PKTS_A, st_a + 1 + w));
         else
            chk("R6", $sformatf("past end a t=%0d w=%0d", t, w), ra, 32'h0);
      end
      if (ok_a && ln_a >= 2) begin
         bus_write(A_IDX, 32'h2);
         bus_read(A_DATA, ra, rb);
         chk("R5", $sformatf("index jump a t=%0d", t), ra, img_word(WORDS_A, PKTS_A, st_a + 3));
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] ra, rb;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      bus_read(A_STAT, ra, rb); chk("R1", "stat a", ra, 32'h0); chk("R1", "stat b", rb, 32'h0);
      bus_read(A_HDR,  ra, rb); chk("R1", "hdr a",  ra, 32'h0);
      bus_read(A_DATA, ra, rb); chk("R1", "data a", ra, 32'h0);
      // R9 mode read-back
      bus_write(A_MODE, 32'h0123_ABCD);
      bus_read(A_MODE, ra, rb); chk("R9", "mode a", ra, 32'h0123_ABCD);
      // R2/R10: header, last payload word, next header, mid-record, last record
      do_req(0, 1'b0);
      do_req(5, 1'b0);
      do_req(6, 1'b0);
      do_req(22, 1'b1);  // R3: start and mode write while busy are ignored
      do_req(41, 1'b0);
      // R7: zero-length terminator on main instance; R8 on truncated instance
      do_req(42, 1'b0);
      do_req(43, 1'b0);
      do_req(60, 1'b0);
      // R7: a new start clears the fail bit
      do_req(10, 1'b0);
      summary();
      $finish;
   end

endmodule